// File: doc/BRIEF.md
# CRT Raster Timing Generator

This block turns a pixel clock into the raster timing of a cathode-ray or flat display: horizontal and vertical sync, a blanking strobe and a display-enable strobe. It also exposes its current character column and scan line so that a pixel fetch engine can follow the beam. All geometry comes from a bank of 8-bit timing registers that software writes through an index/data pair. Horizontal values count characters of eight pixels. Vertical values are up to ten bits wide, so their upper bits live in shared overflow registers and are gathered back together before any compare.

Several fields are stored in a biased form. The horizontal total is characters minus five. The vertical total is lines minus two. The display ends are the last visible column or line. Sync and blank ends keep only their low bits and are matched modulo a power of two. A lock bit protects the eight lowest-indexed registers. Each sync polarity is picked from a separate miscellaneous register. A line-repeat factor and a double-scan bit stretch every scan line vertically.

Top module: `crtc_timing_gen`

## Requirements
- R1: The column counter advances by one every 8 clocks, and a line holds htot+5 characters, numbered 0 to htot+4. htot is register 0x00.
- R2: The scan-line counter advances when the column wraps to 0 after the last repeat of a line. It wraps after line vtot+1. The ten-bit vtot has its low byte in register 0x06.
- R3: Bits 8 and 9 of the vertical fields are held elsewhere. Overflow register 0x07 holds: bit0 vtot[8], bit1 vde[8], bit2 vss[8], bit3 vbs[8], bit5 vtot[9], bit6 vde[9], bit7 vss[9]. Register 0x09 bit5 holds vbs[9]. The low bytes are vde at 0x12, vss at 0x10 and vbs at 0x15.
- R4: disp_en is 1 exactly when column <= hde (register 0x01) and line <= vde.
- R5: Horizontal sync is active from column hss (register 0x04) for L columns, where L = (hse - hss) mod 32 and L = 0 means 32. hse is register 0x05 bits 4:0. A window does not run on past the end of a line.
- R6: Horizontal blank starts at column hbs (register 0x02) and covers L columns, where L = (hbe - hbs) mod 64 and 0 means 64. The 6-bit hbe has bits 4:0 in register 0x03 and bit 5 in register 0x05 bit 7.
- R7: Vertical sync is active from line vss for L lines, where L = (vse - vss) mod 16 and 0 means 16. vse is register 0x11 bits 3:0.
- R8: Vertical blank starts at line vbs and covers L lines, where L = (vbe - vbs) mod 256 and 0 means 256. vbe is register 0x16. blank is the OR of the horizontal and vertical blank windows.
- R9: Register 0x09 sets how often each scan line is repeated: (zoom+1)*(dbl?2:1) times. zoom is bits 4:0 and dbl is bit 7.
- R10: A write on misc_wr sets the polarity. Data bit 6 set makes hsync active-low, and data bit 7 set makes vsync active-low.
- R11: While register 0x11 bit 7 is 1, writes to indices 0x00 to 0x07 are ignored.
- R12: After reset every register and counter is 0. The outputs then show column 0, line 0, hsync=1, vsync=1, blank=1 and disp_en=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the indexed timing bank |
| reg_idx | input | 8 | Register index |
| reg_data | input | 8 | Write data, shared with misc_wr |
| misc_wr | input | 1 | Write strobe for the polarity register |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| blank | output | 1 | Horizontal or vertical blank |
| disp_en | output | 1 | Active picture area |
| char_col | output | COL_W | Current character column |
| scan_line | output | LINE_W | Current scan line |

## Verification
The bench walks whole frames with the bench's own model of each output and compares every character. It targets these corner cases:
- Totals and line positions above 255 and above 511. A design that swapped an overflow bit would end the frame or the sync on the wrong line.
- Sync and blank ends whose stored low bits are smaller than the start. A design that compared the ends directly, or that dropped the sixth blank-end bit, would blank to the end of the line.
- The locked state. A design with leaky protection would change the line length in that state.
- The line-repeat and double-scan settings. A design that skipped the repeats would show a frame too short.

// File: rtl/crtc_pkg.sv
package crtc_pkg;

    localparam int IDX_W  = 8;
    localparam int ZOOM_W = 5;
    localparam int VPOS_W = 10;

    // Indices of the timing bank
    localparam logic [IDX_W-1:0] IX_HTOT = 8'h00;
    localparam logic [IDX_W-1:0] IX_HDE  = 8'h01;
    localparam logic [IDX_W-1:0] IX_HBS  = 8'h02;
    localparam logic [IDX_W-1:0] IX_HBE  = 8'h03;
    localparam logic [IDX_W-1:0] IX_HSS  = 8'h04;
    localparam logic [IDX_W-1:0] IX_HSE  = 8'h05;
    localparam logic [IDX_W-1:0] IX_VTOT = 8'h06;
    localparam logic [IDX_W-1:0] IX_OVF  = 8'h07;
    localparam logic [IDX_W-1:0] IX_REP  = 8'h09;
    localparam logic [IDX_W-1:0] IX_VSS  = 8'h10;
    localparam logic [IDX_W-1:0] IX_VSE  = 8'h11;
    localparam logic [IDX_W-1:0] IX_VDE  = 8'h12;
    localparam logic [IDX_W-1:0] IX_VBS  = 8'h15;
    localparam logic [IDX_W-1:0] IX_VBE  = 8'h16;
    localparam logic [IDX_W-1:0] LOCK_LIMIT = 8'h08;

    typedef struct packed {
        logic [7:0]        htot;
        logic [7:0]        hde;
        logic [7:0]        hbs;
        logic [5:0]        hbe;
        logic [7:0]        hss;
        logic [4:0]        hse;
        logic [VPOS_W-1:0] vtot;
        logic [VPOS_W-1:0] vde;
        logic [VPOS_W-1:0] vss;
        logic [3:0]        vse;
        logic [VPOS_W-1:0] vbs;
        logic [7:0]        vbe;
        logic              dbl;
        logic [ZOOM_W-1:0] zoom;
        logic              hpol;
        logic              vpol;
    } crtc_cfg_t;

    // Window that opens at start and closes on the first count whose
    // masked bits equal endv; a zero length means one full modulus.
    function automatic logic win_hit(input logic [15:0] cnt,
                                     input logic [15:0] start,
                                     input logic [15:0] endv,
                                     input logic [15:0] mask);
        logic [15:0] len;
        len = (endv - start) & mask;
        if (cnt < start)
            return 1'b0;
        if (len == 16'd0)
            return ((cnt - start) <= mask);
        return ((cnt - start) < len);
    endfunction

endpackage

// File: rtl/crtc_regs.sv
module crtc_regs
    import crtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic [7:0]       reg_data,
    input  logic             misc_wr,
    output crtc_cfg_t        cfg,
    output logic             prot_q
);
    crtc_cfg_t cfg_q;
    logic      locked;

    assign locked = prot_q && (reg_idx < LOCK_LIMIT);
    assign cfg    = cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            prot_q <= 1'b0;
        end else begin
            if (misc_wr) begin
                cfg_q.hpol <= reg_data[6];
                cfg_q.vpol <= reg_data[7];
            end
            if (reg_wr && !locked) begin
                case (reg_idx)
                    IX_HTOT: cfg_q.htot <= reg_data;
                    IX_HDE:  cfg_q.hde  <= reg_data;
                    IX_HBS:  cfg_q.hbs  <= reg_data;
                    IX_HBE:  cfg_q.hbe[4:0] <= reg_data[4:0];
                    IX_HSS:  cfg_q.hss  <= reg_data;
                    IX_HSE: begin
                        cfg_q.hse    <= reg_data[4:0];
                        cfg_q.hbe[5] <= reg_data[7];
                    end
                    IX_VTOT: cfg_q.vtot[7:0] <= reg_data;
                    IX_OVF: begin
                        cfg_q.vtot[8] <= reg_data[0];
                        cfg_q.vde[8]  <= reg_data[1];
                        cfg_q.vss[8]  <= reg_data[2];
                        cfg_q.vbs[8]  <= reg_data[3];
                        cfg_q.vtot[9] <= reg_data[5];
                        cfg_q.vde[9]  <= reg_data[6];
                        cfg_q.vss[9]  <= reg_data[7];
                    end
                    IX_REP: begin
                        cfg_q.dbl    <= reg_data[7];
                        cfg_q.vbs[9] <= reg_data[5];
                        cfg_q.zoom   <= reg_data[ZOOM_W-1:0];
                    end
                    IX_VSS: cfg_q.vss[7:0] <= reg_data;
                    IX_VSE: begin
                        cfg_q.vse <= reg_data[3:0];
                        prot_q    <= reg_data[7];
                    end
                    IX_VDE: cfg_q.vde[7:0] <= reg_data;
                    IX_VBS: cfg_q.vbs[7:0] <= reg_data;
                    IX_VBE: cfg_q.vbe <= reg_data;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/crtc_counters.sv
module crtc_counters
    import crtc_pkg::*;
#(
    parameter int PIX_PER_CHAR = 8,
    parameter int COL_W        = 9,
    parameter int LINE_W       = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        htot,
    input  logic [VPOS_W-1:0] vtot,
    input  logic              dbl,
    input  logic [ZOOM_W-1:0] zoom,
    output logic [COL_W-1:0]  col,
    output logic [LINE_W-1:0] line
);
    localparam int PXW  = (PIX_PER_CHAR > 1) ? $clog2(PIX_PER_CHAR) : 1;
    localparam int REPW = ZOOM_W + 2;

    logic [PXW-1:0]    px_q;
    logic [COL_W-1:0]  col_q;
    logic [LINE_W-1:0] line_q;
    logic [REPW-1:0]   rep_q;
    logic [REPW-1:0]   rep_lim;
    logic              char_end, col_last, line_last, rep_last;

    assign char_end  = (px_q == PXW'(PIX_PER_CHAR - 1));
    assign col_last  = (col_q >= COL_W'(htot) + COL_W'(4));
    assign line_last = (line_q >= LINE_W'(vtot) + LINE_W'(1));
    assign rep_lim   = ((REPW'(zoom) + REPW'(1)) << dbl) - REPW'(1);
    assign rep_last  = (rep_q >= rep_lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            px_q   <= '0;
            col_q  <= '0;
            line_q <= '0;
            rep_q  <= '0;
        end else begin
            px_q <= char_end ? '0 : px_q + PXW'(1);
            if (char_end) begin
                if (col_last) begin
                    col_q <= '0;
                    if (rep_last) begin
                        rep_q  <= '0;
                        line_q <= line_last ? '0 : line_q + LINE_W'(1);
                    end else begin
                        rep_q <= rep_q + REPW'(1);
                    end
                end else begin
                    col_q <= col_q + COL_W'(1);
                end
            end
        end
    end

    assign col  = col_q;
    assign line = line_q;
endmodule

// File: rtl/crtc_decode.sv
module crtc_decode
    import crtc_pkg::*;
#(
    parameter int COL_W  = 9,
    parameter int LINE_W = 11
) (
    input  logic [COL_W-1:0]  col,
    input  logic [LINE_W-1:0] line,
    input  logic [7:0]        hde,
    input  logic [7:0]        hbs,
    input  logic [5:0]        hbe,
    input  logic [7:0]        hss,
    input  logic [4:0]        hse,
    input  logic [VPOS_W-1:0] vde,
    input  logic [VPOS_W-1:0] vss,
    input  logic [3:0]        vse,
    input  logic [VPOS_W-1:0] vbs,
    input  logic [7:0]        vbe,
    input  logic              hpol,
    input  logic              vpol,
    output logic              hsync,
    output logic              vsync,
    output logic              blank,
    output logic              disp_en
);
    logic [15:0] c16, l16;
    logic        hs_act, vs_act, hb_act, vb_act;

    assign c16 = 16'(col);
    assign l16 = 16'(line);

    always_comb begin
        hs_act = win_hit(c16, 16'(hss), 16'(hse), 16'h001f);
        hb_act = win_hit(c16, 16'(hbs), 16'(hbe), 16'h003f);
        vs_act = win_hit(l16, 16'(vss), 16'(vse), 16'h000f);
        vb_act = win_hit(l16, 16'(vbs), 16'(vbe), 16'h00ff);
    end

    assign hsync   = hs_act ^ hpol;
    assign vsync   = vs_act ^ vpol;
    assign blank   = hb_act | vb_act;
    assign disp_en = (c16 <= 16'(hde)) && (l16 <= 16'(vde));
endmodule

// File: rtl/crtc_timing_gen.sv
module crtc_timing_gen
    import crtc_pkg::*;
#(
    parameter int PIX_PER_CHAR = 8,
    parameter int COL_W        = 9,
    parameter int LINE_W       = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [7:0]        reg_idx,
    input  logic [7:0]        reg_data,
    input  logic              misc_wr,
    output logic              hsync,
    output logic              vsync,
    output logic              blank,
    output logic              disp_en,
    output logic [COL_W-1:0]  char_col,
    output logic [LINE_W-1:0] scan_line
);
    crtc_cfg_t cfg;
    logic      prot;

    crtc_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .reg_wr   (reg_wr),
        .reg_idx  (reg_idx),
        .reg_data (reg_data),
        .misc_wr  (misc_wr),
        .cfg      (cfg),
        .prot_q   (prot)
    );

    crtc_counters #(
        .PIX_PER_CHAR (PIX_PER_CHAR),
        .COL_W        (COL_W),
        .LINE_W       (LINE_W)
    ) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .htot (cfg.htot),
        .vtot (cfg.vtot),
        .dbl  (cfg.dbl),
        .zoom (cfg.zoom),
        .col  (char_col),
        .line (scan_line)
    );

    crtc_decode #(
        .COL_W  (COL_W),
        .LINE_W (LINE_W)
    ) u_dec (
        .col     (char_col),
        .line    (scan_line),
        .hde     (cfg.hde),
        .hbs     (cfg.hbs),
        .hbe     (cfg.hbe),
        .hss     (cfg.hss),
        .hse     (cfg.hse),
        .vde     (cfg.vde),
        .vss     (cfg.vss),
        .vse     (cfg.vse),
        .vbs     (cfg.vbs),
        .vbe     (cfg.vbe),
        .hpol    (cfg.hpol),
        .vpol    (cfg.vpol),
        .hsync   (hsync),
        .vsync   (vsync),
        .blank   (blank),
        .disp_en (disp_en)
    );
endmodule

// File: rtl/crtc_timing_chk.sv
module crtc_timing_chk
    import crtc_pkg::*;
#(
    parameter int COL_W  = 9,
    parameter int LINE_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [7:0]        reg_idx,
    input logic              prot,
    input crtc_cfg_t         cfg,
    input logic [COL_W-1:0]  char_col,
    input logic [LINE_W-1:0] scan_line,
    input logic              hsync,
    input logic              vsync
);
    AST_COL_STEP: assert property (@(posedge clk) disable iff (rst)
        (char_col != $past(char_col)) |->
            (char_col == $past(char_col) + COL_W'(1) || char_col == '0)); // R1

    AST_LINE_STEP: assert property (@(posedge clk) disable iff (rst)
        (scan_line != $past(scan_line)) |->
            (char_col == '0 &&
             (scan_line == $past(scan_line) + LINE_W'(1) || scan_line == '0))); // R2

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (prot && reg_wr && reg_idx < LOCK_LIMIT) |=>
            ($stable(cfg.htot) && $stable(cfg.hde) && $stable(cfg.hss) &&
             $stable(cfg.vtot))); // R11

    AST_HSYNC_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($stable(char_col) && $stable(cfg)) |-> $stable(hsync)); // R5

    AST_VSYNC_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($stable(scan_line) && $stable(cfg)) |-> $stable(vsync)); // R7
endmodule

bind crtc_timing_gen crtc_timing_chk #(
    .COL_W  (COL_W),
    .LINE_W (LINE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_idx   (reg_idx),
    .prot      (prot),
    .cfg       (cfg),
    .char_col  (char_col),
    .scan_line (scan_line),
    .hsync     (hsync),
    .vsync     (vsync)
);

// File: tb/crtc_timing_gen_tb.sv
module crtc_timing_gen_tb;
    localparam int PIX = 8;
    localparam int CW  = 9;
    localparam int LW  = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_wr = 1'b0;
    logic misc_wr = 1'b0;
    logic [7:0] reg_idx = '0;
    logic [7:0] reg_data = '0;
    logic hsync, vsync, blank, disp_en;
    logic [CW-1:0] char_col;
    logic [LW-1:0] scan_line;

    int checks = 0;
    int errors = 0;
    logic armed = 1'b0;
    int ph = 0;

    typedef struct {
        int    col;
        int    line;
        logic  hs, vs, bl, de;
        string tag;
    } item_t;
    item_t sb[$];

    // bench view of the intended timing
    int c_htot, c_hde, c_hbs, c_hbe, c_hss, c_hse;
    int c_vtot, c_vde, c_vss, c_vse, c_vbs, c_vbe;
    int c_dbl, c_zoom, c_hpol, c_vpol;

    always #10 clk = ~clk;

    crtc_timing_gen #(.PIX_PER_CHAR(PIX), .COL_W(CW), .LINE_W(LW)) u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_data(reg_data), .misc_wr(misc_wr), .hsync(hsync), .vsync(vsync),
        .blank(blank), .disp_en(disp_en), .char_col(char_col), .scan_line(scan_line)
    );

    function automatic logic win(int cnt, int start, int endv, int bits);
        int per = 1 << bits;
        int len = ((endv - start) % per + per) % per;
        if (len == 0) len = per;
        return (cnt >= start) && (cnt < start + len);
    endfunction

    function automatic item_t model(int k, string tag);
        item_t it;
        int ht = c_htot + 5;
        int vt = c_vtot + 2;
        int rp = (c_zoom + 1) * (c_dbl ? 2 : 1);
        it.col  = k % ht;
        it.line = (k / ht / rp) % vt;
        it.hs   = win(it.col, c_hss, c_hse, 5) ^ c_hpol[0];
        it.vs   = win(it.line, c_vss, c_vse, 4) ^ c_vpol[0];
        it.bl   = win(it.col, c_hbs, c_hbe, 6) | win(it.line, c_vbs, c_vbe, 8);
        it.de   = (it.col <= c_hde) && (it.line <= c_vde);
        it.tag  = tag;
        return it;
    endfunction

    // monitor: one comparison per character, one clock into it
    always @(negedge clk) begin
        if (armed && sb.size() > 0) begin
            if (ph == 0) begin
                item_t e;
                e = sb.pop_front();
                checks++;
                if (int'(char_col) != e.col || int'(scan_line) != e.line ||
                    hsync !== e.hs || vsync !== e.vs || blank !== e.bl || disp_en !== e.de) begin
                    errors++;
                    $display("FAIL %s: got col=%0d line=%0d hs=%b vs=%b bl=%b de=%b, exp col=%0d line=%0d hs=%b vs=%b bl=%b de=%b",
                             e.tag, char_col, scan_line, hsync, vsync, blank, disp_en,
                             e.col, e.line, e.hs, e.vs, e.bl, e.de);
                end
            end
            ph = (ph + 1) % PIX;
        end else begin
            ph = 0;
        end
    end

    task automatic wr(input logic [7:0] idx, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = idx; reg_data = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic mwr(input logic [7:0] d);
        @(negedge clk);
        misc_wr = 1'b1; reg_data = d;
        @(negedge clk);
        misc_wr = 1'b0;
    endtask

    task automatic program_cfg();
        logic [9:0] vt, vd, vs, vb;
        logic [5:0] hb;
        vt = c_vtot[9:0]; vd = c_vde[9:0]; vs = c_vss[9:0]; vb = c_vbs[9:0];
        hb = c_hbe[5:0];
        wr(8'h11, {4'h0, c_vse[3:0]});
        wr(8'h00, c_htot[7:0]);
        wr(8'h01, c_hde[7:0]);
        wr(8'h02, c_hbs[7:0]);
        wr(8'h03, {3'b000, hb[4:0]});
        wr(8'h04, c_hss[7:0]);
        wr(8'h05, {hb[5], 2'b00, c_hse[4:0]});
        wr(8'h06, vt[7:0]);
        wr(8'h07, {vs[9], vd[9], vt[9], 1'b0, vb[8], vs[8], vd[8], vt[8]});
        wr(8'h09, {c_dbl[0], 1'b0, vb[9], c_zoom[4:0]});
        wr(8'h10, vs[7:0]);
        wr(8'h12, vd[7:0]);
        wr(8'h15, vb[7:0]);
        wr(8'h16, c_vbe[7:0]);
        mwr({c_vpol[0], c_hpol[0], 6'b0});
    endtask

    // driver: find a frame start, queue a whole frame of expectations
    task automatic run_frame(string tag);
        int pl = 0;
        int n;
        forever begin
            @(negedge clk);
            if (char_col == '0 && scan_line == '0 && pl != 0) break;
            pl = int'(scan_line);
        end
        #1;
        n = (c_htot + 5) * (c_vtot + 2) * (c_zoom + 1) * (c_dbl ? 2 : 1);
        for (int k = 0; k < n; k++) sb.push_back(model(k, tag));
        armed = 1'b1;
        wait (sb.size() == 0);
        armed = 1'b0;
    endtask

    task automatic cfg_a();
        c_htot = 5;  c_hde = 5;  c_hbs = 6;  c_hbe = 9;  c_hss = 7;  c_hse = 8;
        c_vtot = 4;  c_vde = 3;  c_vbs = 4;  c_vbe = 6;  c_vss = 5;  c_vse = 6;
        c_dbl = 0;   c_zoom = 0; c_hpol = 0; c_vpol = 0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, got timeout, exp completion");
        summary();
        $finish;
    end

    initial begin
        c_htot = 0; c_hde = 0; c_hbs = 0; c_hbe = 0; c_hss = 0; c_hse = 0;
        c_vtot = 0; c_vde = 0; c_vbs = 0; c_vbe = 0; c_vss = 0; c_vse = 0;
        c_dbl = 0;  c_zoom = 0; c_hpol = 0; c_vpol = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state, column 0 line 0, all windows open
        checks++;
        if (char_col != '0 || scan_line != '0 || hsync !== 1'b1 || vsync !== 1'b1 ||
            blank !== 1'b1 || disp_en !== 1'b1) begin
            errors++;
            $display("FAIL R12: got col=%0d line=%0d hs=%b vs=%b bl=%b de=%b, exp 0 0 1 1 1 1",
                     char_col, scan_line, hsync, vsync, blank, disp_en);
        end
        run_frame("R12 R1 R2 reset defaults");

        // basic geometry
        cfg_a();
        program_cfg();
        run_frame("R1 R2 R4 R5 R6 R7 R8 basic");

        // R11: lock, then try to alter protected registers
        wr(8'h11, 8'h86);
        wr(8'h00, 8'd9);
        wr(8'h01, 8'd1);
        wr(8'h06, 8'd9);
        run_frame("R11 locked writes ignored");

        // R5 R6: ends below start in their low bits, blank end bit 5
        cfg_a();
        c_htot = 45; c_hde = 30; c_hbs = 33; c_hbe = 40; c_hss = 35; c_hse = 37;
        program_cfg();
        run_frame("R5 R6 wrapped ends");

        // R10: both polarities inverted
        cfg_a();
        c_hpol = 1; c_vpol = 1;
        program_cfg();
        run_frame("R10 active-low sync");

        // R9: double scan with a zoom of two
        cfg_a();
        c_dbl = 1; c_zoom = 1;
        program_cfg();
        run_frame("R9 line repeat");

        // R3 R7 R8: bit 8 of the vertical fields
        cfg_a();
        c_htot = 0; c_hde = 2; c_hbs = 3; c_hbe = 4; c_hss = 1; c_hse = 2;
        c_vtot = 257; c_vde = 256; c_vbs = 257; c_vbe = 259; c_vss = 258; c_vse = 259;
        program_cfg();
        run_frame("R3 R7 R8 bit8 overflow");

        // R3: bit 9 of the vertical fields
        c_vtot = 513; c_vde = 512; c_vbs = 513; c_vbe = 515; c_vss = 514; c_vse = 515;
        program_cfg();
        run_frame("R3 R2 bit9 overflow");

        summary();
        $finish;
    end
endmodule